// File: doc/BRIEF.md
# Host-Target Debug Packet Engine

This block sits between a host link and a target system. It receives command packets as a stream of 64-bit words and carries each command out. A command can read a block of 64-bit memory words, write a block of them, or read or write one control register of a core. Each command is answered with an acknowledge header, followed by any data the command returns. The engine checks a running sequence number on every packet. Any protocol violation stops it for good.

The engine holds three registers for each core: a reset control register, an outbound mailbox that the target fills, and an inbound mailbox that the host fills. The mailboxes follow handover rules. Reading the outbound mailbox empties it. A host write to an inbound mailbox that is still occupied is dropped. All cores leave reset held. A global reset flag stays set until the host first releases a core through its reset register. The done output reports that the flag has been released and no core is running.

Top module: `host_debug_engine`

## Requirements
- R1: A packet starts with two header words. Word 0 holds the command in bits [3:0], the word count in bits [31:16] and the sequence number in bits [63:32]. Word 1 holds the address. Command codes are 0 read memory, 1 write memory, 2 read register, 3 write register, 4 acknowledge. Every acknowledge header is word 0 = {sequence, size, 12'h0, 4'd4} followed by word 1 = 0.
- R2: The expected sequence number is 1 after reset and increases by 1 after each completed command. A header with any other number raises err.
- R3: A memory read sends an acknowledge of size N carrying the packet's sequence number. It then sends N words read from byte addresses (addr+i)*8, i = 0..N-1. The memory returns read data one cycle after mem_re.
- R4: A memory write stores its N payload words at byte addresses (addr+i)*8. The acknowledge, of size 0, is sent only after the last store.
- R5: For register commands, address bits [39:20] select the core and bits [19:0] the register. The size must be 1, and the core must be below NCORES or equal to 20'hFFFFF; otherwise err is raised. The reply is an acknowledge of size 1 followed by the register's value before the command.
- R6: Core 20'hFFFFF is the system space. Register 0 there reads NCORES, every other register reads 0, and writes change nothing.
- R7: Register 1 is the outbound mailbox, loaded by the target through tgt_tohost_set. Any register command that addresses it returns the old value and leaves it at 0, unless the command itself writes it, in which case it takes the written value.
- R8: Register 2 is the inbound mailbox, visible on fromhost_q. A host write is dropped while it is nonzero, and tgt_fromhost_ack clears it.
- R9: Register 0 is the reset control register. core_reset of every core is 1 after reset. A write sets the addressed core's reset to bit 0 of the value. The first write with bit 0 equal to 0 releases the global reset flag, and the flag is never set again.
- R10: done is 1 exactly when the global reset flag is released and no core_running bit is set.
- R11: A command code above 3 raises err. err is sticky, holds in_ready low, and clears only on rst_n.
- R12: While out_valid is high and out_ready low, out_valid and out_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host word valid |
| in_ready | output | 1 | Engine accepts a host word |
| in_data | input | 64 | Host word |
| out_valid | output | 1 | Response word valid |
| out_ready | input | 1 | Host takes the response word |
| out_data | output | 64 | Response word |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MAW | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, one cycle after mem_re |
| tgt_tohost_set | input | NCORES | Target loads its outbound mailbox |
| tgt_tohost_val | input | 64*NCORES | Value per core for the outbound mailbox |
| tgt_fromhost_ack | input | NCORES | Target consumed its inbound mailbox |
| fromhost_q | output | 64*NCORES | Inbound mailbox contents per core |
| core_reset | output | NCORES | Reset level per core |
| core_running | input | NCORES | Core reports it is running |
| done | output | 1 | Reset released and all cores idle |
| err | output | 1 | Sticky protocol error |

## Verification
Memory is exercised with writes of one to four words at staggered addresses, then overlapping reads of mixed lengths, plus a zero-length read. This exposes errors in word ordering, address scaling and counting, and shows whether the acknowledge comes before or after the stores. Register traffic walks each mailbox through full, empty and dropped-write states, and toggles reset to separate the global flag from the per-core reset level. A stalled response and one packet for each error kind (wrong sequence, unknown command, bad size, bad core) show that the output holds and that err stops the engine until reset.

// File: rtl/host_debug_engine.sv
module host_debug_engine #(
  parameter int NCORES = 2,
  parameter int MAW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [63:0]          in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [63:0]          out_data,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [MAW-1:0]       mem_addr,
  output logic [63:0]          mem_wdata,
  input  logic [63:0]          mem_rdata,
  input  logic [NCORES-1:0]    tgt_tohost_set,
  input  logic [NCORES*64-1:0] tgt_tohost_val,
  input  logic [NCORES-1:0]    tgt_fromhost_ack,
  output logic [NCORES*64-1:0] fromhost_q,
  output logic [NCORES-1:0]    core_reset,
  input  logic [NCORES-1:0]    core_running,
  output logic                 done,
  output logic                 err
);
  localparam logic [3:0] C_RDMEM = 4'd0;
  localparam logic [3:0] C_WRMEM = 4'd1;
  localparam logic [3:0] C_RDCR  = 4'd2;
  localparam logic [3:0] C_WRCR  = 4'd3;
  localparam logic [3:0] C_ACK   = 4'd4;
  localparam logic [19:0] SYS_ID = 20'hFFFFF;

  typedef enum logic [3:0] {
    S_H0, S_H1, S_WPAY, S_CPAY, S_CEXEC, S_ACK0, S_ACK1,
    S_RD, S_RDW, S_DATA, S_CRD, S_ERR
  } state_t;

  state_t      state;
  logic [3:0]  cmd_q;
  logic [31:0] exp_seq;
  logic [15:0] size_q, ack_size, cnt;
  logic [63:0] addr_q, obuf, wbuf, cur_val;
  logic        rst_flag;
  logic [63:0] tohost   [NCORES];
  logic [63:0] fromhost [NCORES];

  wire in_hs  = in_valid && in_ready;
  wire out_hs = out_valid && out_ready;
  wire [19:0] core_id = addr_q[39:20];
  wire [19:0] regno   = addr_q[19:0];
  wire        sys     = core_id == SYS_ID;
  wire [19:0] in_core = in_data[39:20];
  wire        bad_core = (in_core != SYS_ID) && (in_core >= 20'(NCORES));
  wire        is_cr   = (cmd_q == C_RDCR) || (cmd_q == C_WRCR);
  wire [63:0] word_addr = addr_q + {48'd0, cnt};
  wire [63:0] byte_addr = word_addr << 3;

  assign in_ready  = (state == S_H0) || (state == S_H1) || (state == S_WPAY) || (state == S_CPAY);
  assign out_valid = (state == S_ACK0) || (state == S_ACK1) || (state == S_DATA) || (state == S_CRD);
  assign out_data  = (state == S_ACK0) ? {exp_seq, ack_size, 12'h000, C_ACK} :
                     (state == S_ACK1) ? 64'd0 : obuf;
  assign mem_we    = (state == S_WPAY) && in_valid;
  assign mem_wdata = in_data;
  assign mem_re    = state == S_RD;
  assign mem_addr  = byte_addr[MAW-1:0];
  assign done      = !rst_flag && !(|core_running);
  assign err       = state == S_ERR;

  for (genvar g = 0; g < NCORES; g++) begin : g_fh
    assign fromhost_q[g*64 +: 64] = fromhost[g];
  end

  always_comb begin
    cur_val = 64'd0;
    if (sys) begin
      if (regno == 20'd0) cur_val = 64'(NCORES);
    end else begin
      for (int c = 0; c < NCORES; c++) begin
        if (core_id == 20'(c)) begin
          case (regno)
            20'd0:   cur_val = {63'd0, core_reset[c]};
            20'd1:   cur_val = tohost[c];
            20'd2:   cur_val = fromhost[c];
            default: cur_val = 64'd0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_H0;
      cmd_q      <= C_RDMEM;
      exp_seq    <= 32'd1;
      size_q     <= '0;
      ack_size   <= '0;
      cnt        <= '0;
      addr_q     <= '0;
      obuf       <= '0;
      wbuf       <= '0;
      rst_flag   <= 1'b1;
      core_reset <= '1;
      for (int c = 0; c < NCORES; c++) begin
        tohost[c]   <= '0;
        fromhost[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCORES; c++) begin
        if (tgt_tohost_set[c])   tohost[c]   <= tgt_tohost_val[c*64 +: 64];
        if (tgt_fromhost_ack[c]) fromhost[c] <= '0;
      end
      case (state)
        S_H0: if (in_hs) begin
          cmd_q  <= in_data[3:0];
          size_q <= in_data[31:16];
          if (in_data[63:32] != exp_seq || in_data[3:0] > C_WRCR) state <= S_ERR;
          else state <= S_H1;
        end
        S_H1: if (in_hs) begin
          addr_q <= in_data;
          cnt    <= '0;
          case (cmd_q)
            C_RDMEM: begin ack_size <= size_q; state <= S_ACK0; end
            C_WRMEM: begin ack_size <= 16'd0; state <= (size_q == 16'd0) ? S_ACK0 : S_WPAY; end
            default: begin
              ack_size <= 16'd1;
              if (size_q != 16'd1 || bad_core) state <= S_ERR;
              else state <= (cmd_q == C_WRCR) ? S_CPAY : S_CEXEC;
            end
          endcase
        end
        S_WPAY: if (in_hs) begin
          cnt <= cnt + 16'd1;
          if (cnt == size_q - 16'd1) state <= S_ACK0;
        end
        S_CPAY: if (in_hs) begin
          wbuf  <= in_data;
          state <= S_CEXEC;
        end
        S_CEXEC: begin
          obuf  <= cur_val;
          state <= S_ACK0;
          if (!sys) begin
            for (int c = 0; c < NCORES; c++) begin
              if (core_id == 20'(c)) begin
                if (regno == 20'd1) tohost[c] <= '0;
                if (cmd_q == C_WRCR) begin
                  case (regno)
                    20'd0: begin
                      core_reset[c] <= wbuf[0];
                      if (!wbuf[0]) rst_flag <= 1'b0;
                    end
                    20'd1: tohost[c] <= wbuf;
                    20'd2: if (fromhost[c] == 64'd0) fromhost[c] <= wbuf;
                    default: ;
                  endcase
                end
              end
            end
          end
        end
        S_ACK0: if (out_hs) state <= S_ACK1;
        S_ACK1: if (out_hs) begin
          if (cmd_q == C_RDMEM && size_q != 16'd0) state <= S_RD;
          else if (is_cr) state <= S_CRD;
          else begin
            exp_seq <= exp_seq + 32'd1;
            state   <= S_H0;
          end
        end
        S_RD:  state <= S_RDW;
        S_RDW: begin
          obuf  <= mem_rdata;
          state <= S_DATA;
        end
        S_DATA: if (out_hs) begin
          cnt <= cnt + 16'd1;
          if (cnt == size_q - 16'd1) begin
            exp_seq <= exp_seq + 32'd1;
            state   <= S_H0;
          end else state <= S_RD;
        end
        S_CRD: if (out_hs) begin
          exp_seq <= exp_seq + 32'd1;
          state   <= S_H0;
        end
        default: state <= S_ERR;
      endcase
    end
  end

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  a_r11_no_input_after_err: assert property (@(posedge clk) disable iff (!rst_n) err |-> !in_ready);
  a_r12_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r9_release_final: assert property (@(posedge clk) disable iff (!rst_n) !rst_flag |=> !rst_flag);
  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> !mem_re);
  a_r4_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_re, mem_we}));
endmodule

// File: tb/host_debug_engine_test.sv
module host_debug_engine_test;
  localparam int CLK = 10;
  localparam int NC = 2;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [63:0] in_data = 0;
  logic in_ready, out_valid, mem_re, mem_we, done, err;
  logic [63:0] out_data, mem_wdata;
  logic [63:0] mem_rdata = 0;
  logic [AW-1:0] mem_addr;
  logic [NC-1:0] tgt_tohost_set = 0, tgt_fromhost_ack = 0, core_running = 0, core_reset;
  logic [NC*64-1:0] tgt_tohost_val = 0, fromhost_q;

  int total = 0, fails = 0;
  logic [31:0] seq = 1;
  logic [63:0] mem [512];
  logic [63:0] sh  [512];

  host_debug_engine #(.NCORES(NC), .MAW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tgt_tohost_set(tgt_tohost_set), .tgt_tohost_val(tgt_tohost_val),
    .tgt_fromhost_ack(tgt_fromhost_ack), .fromhost_q(fromhost_q), .core_reset(core_reset),
    .core_running(core_running), .done(done), .err(err));

  always #(CLK/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[AW-1:3]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[AW-1:3]];
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] hdr(input logic [3:0] cmd, input logic [15:0] n, input logic [31:0] s);
    return {s, n, 12'h000, cmd};
  endfunction

  function automatic logic [63:0] pat(input int a, input int k);
    return (64'(a) * 64'h0101_0101_0101_0101) ^ {32'(k) + 32'h5A00_0000, 32'h0};
  endfunction

  task automatic send(input logic [63:0] w);
    @(negedge clk);
    in_valid = 1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic recv(input string req, input logic [63:0] exp);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    check(req, out_data, exp);
    out_ready = 1;
    @(posedge clk); #1 out_ready = 0;
  endtask

  task automatic mem_write(input int a, input int n, input int k);
    send(hdr(4'd1, 16'(n), seq));
    send(64'(a));
    for (int i = 0; i < n; i++) begin
      sh[a+i] = pat(a+i, k);
      send(pat(a+i, k));
    end
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    for (int i = 0; i < n; i++) check("R4 stored before ack", mem[a+i], sh[a+i]);
    recv("R4 ack header", hdr(4'd4, 16'd0, seq));
    recv("R1 ack word1", 64'd0);
    seq++;
  endtask

  task automatic mem_read(input int a, input int n);
    send(hdr(4'd0, 16'(n), seq));
    send(64'(a));
    recv("R3 ack header", hdr(4'd4, 16'(n), seq));
    recv("R1 ack word1", 64'd0);
    for (int i = 0; i < n; i++) recv("R3 read data", sh[a+i]);
    seq++;
  endtask

  task automatic cr(input bit wr, input logic [19:0] core, input logic [19:0] rn,
                    input logic [63:0] wv, input logic [63:0] old, input string req);
    send(hdr(wr ? 4'd3 : 4'd2, 16'd1, seq));
    send({24'd0, core, rn});
    if (wr) send(wv);
    recv("R5 ack header", hdr(4'd4, 16'd1, seq));
    recv("R1 ack word1", 64'd0);
    recv(req, old);
    seq++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; seq = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = 0; sh[i] = 0; end
    do_reset();
    @(negedge clk);
    check("R11 reset err", {63'd0, err}, 0);
    check("R1 reset in_ready", {63'd0, in_ready}, 1);
    check("R12 reset out_valid", {63'd0, out_valid}, 0);
    check("R9 reset cores held", {62'd0, core_reset}, 64'd3);
    check("R10 done before release", {63'd0, done}, 0);

    for (int b = 0; b < 8; b++) mem_write(b * 5, (b % 4) + 1, b);
    for (int a = 0; a < 40; a += 3) mem_read(a, ((a / 3) % 4) + 1);
    mem_read(7, 0);

    // R12 stalled acknowledge
    send(hdr(4'd0, 16'd1, seq));
    send(64'd5);
    repeat (4) @(negedge clk);
    check("R12 valid held", {63'd0, out_valid}, 1);
    check("R12 data held", out_data, hdr(4'd4, 16'd1, seq));
    recv("R3 ack header", hdr(4'd4, 16'd1, seq));
    recv("R1 ack word1", 64'd0);
    recv("R3 read data", sh[5]);
    seq++;

    // R7 outbound mailbox
    @(negedge clk);
    tgt_tohost_set = 2'b10; tgt_tohost_val = {64'h1234, 64'd0};
    @(negedge clk); tgt_tohost_set = 0;
    cr(0, 20'd1, 20'd1, 0, 64'h1234, "R7 read value");
    cr(0, 20'd1, 20'd1, 0, 64'h0, "R7 cleared by read");
    cr(1, 20'd1, 20'd1, 64'h55, 64'h0, "R7 write old");
    cr(0, 20'd1, 20'd1, 0, 64'h55, "R7 written value");

    // R8 inbound mailbox
    cr(1, 20'd0, 20'd2, 64'd5, 64'd0, "R8 first write old");
    @(negedge clk); check("R8 mailbox loaded", fromhost_q[63:0], 64'd5);
    cr(1, 20'd0, 20'd2, 64'd9, 64'd5, "R8 full write old");
    @(negedge clk); check("R8 full write dropped", fromhost_q[63:0], 64'd5);
    tgt_fromhost_ack = 2'b01;
    @(negedge clk); tgt_fromhost_ack = 0;
    check("R8 ack clears", fromhost_q[63:0], 64'd0);
    cr(1, 20'd0, 20'd2, 64'd9, 64'd0, "R8 write after ack old");
    @(negedge clk); check("R8 accepted", fromhost_q[63:0], 64'd9);
    check("R8 other core untouched", fromhost_q[127:64], 64'd0);

    // R9 R10 reset control
    cr(0, 20'd0, 20'd0, 0, 64'd1, "R9 reset reads held");
    @(negedge clk); check("R10 done while flag set", {63'd0, done}, 0);
    cr(1, 20'd0, 20'd0, 64'd0, 64'd1, "R9 release old");
    @(negedge clk);
    check("R9 core0 released", {62'd0, core_reset}, 64'd2);
    check("R10 done after release", {63'd0, done}, 1);
    core_running = 2'b01;
    @(negedge clk); check("R10 running blocks done", {63'd0, done}, 0);
    core_running = 0;
    cr(1, 20'd0, 20'd0, 64'd1, 64'd0, "R9 reassert old");
    @(negedge clk);
    check("R9 core0 held again", {62'd0, core_reset}, 64'd3);
    check("R9 flag stays released", {63'd0, done}, 1);

    // R6 system space
    cr(0, 20'hFFFFF, 20'd0, 0, 64'(NC), "R6 core count");
    cr(1, 20'hFFFFF, 20'd0, 64'd77, 64'(NC), "R6 write old");
    cr(0, 20'hFFFFF, 20'd0, 0, 64'(NC), "R6 write ignored");
    cr(0, 20'hFFFFF, 20'd5, 0, 64'd0, "R6 other reg zero");
    @(negedge clk); check("R6 no reset effect", {62'd0, core_reset}, 64'd3);

    // error cases
    send(hdr(4'd0, 16'd1, seq + 32'd4));
    check("R2 bad sequence err", {63'd0, err}, 1);
    check("R11 input blocked", {63'd0, in_ready}, 0);
    repeat (3) @(negedge clk);
    check("R11 err sticky", {63'd0, err}, 1);
    do_reset();
    @(negedge clk); check("R11 reset clears err", {63'd0, err}, 0);
    mem_read(5, 1);
    send(hdr(4'd6, 16'd1, seq));
    check("R11 unknown command", {63'd0, err}, 1);
    do_reset();
    send(hdr(4'd4, 16'd0, seq));
    check("R11 ack code from host", {63'd0, err}, 1);
    do_reset();
    send(hdr(4'd2, 16'd2, seq));
    send({24'd0, 20'd0, 20'd1});
    check("R5 bad size", {63'd0, err}, 1);
    do_reset();
    send(hdr(4'd2, 16'd1, seq));
    send({24'd0, 20'd2, 20'd1});
    check("R5 bad core", {63'd0, err}, 1);
    do_reset();
    cr(0, 20'd1, 20'd0, 0, 64'd1, "R2 sequence restarts");
    summary();
  end
endmodule